// File: doc/BRIEF.md
# Retriggerable Finite Pulse Train Generator

This block turns start triggers into pulses. Each rising edge on the gate input launches one generation. A generation is either a single pulse or a finite train of pulses. All timing is counted in active edges of a slow source input, not in system clock cycles: the leading delay, the high time of each pulse, and the low time between pulses. A second counter tallies the pulses of a train and ends it when the programmed count is reached. Gate activity is ignored while a generation runs. When the generation ends, the block waits for the next trigger.

A configuration bit chooses whether the leading delay is inserted before every triggered generation or only before the first one after arming. When the delay is skipped, the output goes high as soon as the trigger is seen. Suggested settings are to set the bit for single pulses and to clear it for trains. The arm input enables the block. Dropping arm cancels any generation in progress, forces the output low and clears both counters. Source and gate are synchronized to the system clock. Another bit selects whether rising or falling source edges are active.

Top module: `pulse_train_gen`

## Requirements
- R1: After reset the pulse output and the done flag are both 0.
- R2: After a trigger the output stays low until the delay count of active source edges is reached, then stays high for the high count of active source edges.
- R3: With the edge select bit at 0, rising source edges are active. With it at 1, falling source edges are active and rising edges are not counted.
- R4: With the train bit at 1, the block produces exactly the programmed number of pulses, separated by low phases of the low count of active source edges, and then stops. With the train bit at 0, exactly one pulse is produced.
- R5: A delay, high, low or pulse count value of 0 behaves as a value of 1.
- R6: A rising gate edge that arrives while a generation is running neither restarts nor extends that generation.
- R7: After a generation ends, the next rising gate edge launches a new, complete generation.
- R8: With the delay-every-trigger bit at 1, the delay precedes every generation. With it at 0, the delay precedes only the first generation after arm rises, and later generations raise the output as soon as the trigger is seen.
- R9: While arm is 0, the output is driven low, done stays 0 and gate edges are ignored. A generation cut short by arm falling leaves no partial count behind.
- R10: At the end of every generation that completes, done is high for exactly one system clock cycle, in the cycle where the output falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Enables generation. Low aborts and holds idle |
| src_in | input | 1 | Timebase input whose active edges are counted |
| gate_in | input | 1 | Start trigger. A rising edge launches a generation |
| cfg_src_fall | input | 1 | 0: rising source edges are active. 1: falling source edges are active |
| cfg_delay_all | input | 1 | 1: delay before every generation. 0: delay only before the first generation after arming |
| cfg_train | input | 1 | 0: single pulse per trigger. 1: finite train per trigger |
| delay_len | input | CNT_W | Leading delay in active source edges (0 treated as 1) |
| high_len | input | CNT_W | Pulse high time in active source edges (0 treated as 1) |
| low_len | input | CNT_W | Low time between pulses in active source edges (0 treated as 1) |
| pulse_total | input | PCNT_W | Pulses per train (0 treated as 1) |
| pulse_out | output | 1 | Generated pulse signal, idle low |
| done | output | 1 | One-cycle strobe at the end of each completed generation |

## Verification
The bound checker checks these properties on every cycle:
- the output falls and done clears in the cycle after arm is seen low;
- done lasts a single cycle and coincides with the falling edge of the output;
- the output changes only after a source strobe, a gate strobe or a disarm;
- the pulse tally never reaches the effective target.

Other behaviours span many source edges and configuration history, so only the directed scenarios can show them:
- the exact delay, high and low counts;
- which source edge polarity counts;
- that a trigger in mid-train is ignored;
- whether the delay is skipped on retriggers;
- that a full train completes after an abort and re-arm.

// File: rtl/pt_pkg.sv
package pt_pkg;
   typedef enum logic [1:0] {
      PT_IDLE  = 2'd0,
      PT_DELAY = 2'd1,
      PT_HIGH  = 2'd2,
      PT_LOW   = 2'd3
   } pt_state_e;
endpackage

// File: rtl/pt_sync_edge.sv
// Multi-stage synchronizer followed by a selectable edge strobe.
module pt_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   input  logic fall_sel,
   output logic stb
);
   logic [STAGES-1:0] chain;
   logic              last_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("pt_sync_edge: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain[STAGES-1];
   end

   assign stb = fall_sel ? (last_q & ~chain[STAGES-1])
                         : (~last_q & chain[STAGES-1]);
endmodule

// File: rtl/pt_phase_cnt.sv
// Counts active source edges within one phase; hit fires on the last one.
module pt_phase_cnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         step,
   input  logic [W-1:0] limit,
   output logic         hit,
   output logic [W-1:0] count
);
   logic [W-1:0] lim_eff;

   if (W < 1) begin : g_bad_width
      $error("pt_phase_cnt: W must be positive");
   end

   assign lim_eff = (limit == '0) ? W'(1) : limit;
   assign hit     = step && (count >= lim_eff - W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count <= '0;
      else if (clr)  count <= '0;
      else if (step) count <= hit ? '0 : count + W'(1);
   end
endmodule

// File: rtl/pt_pulse_cnt.sv
// Tallies finished pulses of a train; last flags the final pulse.
module pt_pulse_cnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   input  logic [W-1:0] total,
   output logic         last,
   output logic [W-1:0] count
);
   logic [W-1:0] tot_eff;

   if (W < 1) begin : g_bad_width
      $error("pt_pulse_cnt: W must be positive");
   end

   assign tot_eff = (total == '0) ? W'(1) : total;
   assign last    = (count >= tot_eff - W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (clr) count <= '0;
      else if (inc) count <= count + W'(1);
   end
endmodule

// File: rtl/pulse_train_gen.sv
module pulse_train_gen
   import pt_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int PCNT_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic              src_in,
   input  logic              gate_in,
   input  logic              cfg_src_fall,
   input  logic              cfg_delay_all,
   input  logic              cfg_train,
   input  logic [CNT_W-1:0]  delay_len,
   input  logic [CNT_W-1:0]  high_len,
   input  logic [CNT_W-1:0]  low_len,
   input  logic [PCNT_W-1:0] pulse_total,
   output logic              pulse_out,
   output logic              done
);
   if (CNT_W < 1 || PCNT_W < 1) begin : g_bad_widths
      $error("pulse_train_gen: counter widths must be positive");
   end

   pt_state_e          state, state_n;
   logic               src_stb, gate_stb;
   logic               first_used;
   logic               first_set;
   logic               finish;
   logic               pulse_inc;
   logic               phase_hit;
   logic [CNT_W-1:0]   phase_lim;
   logic [CNT_W-1:0]   phase_count;
   logic               pulse_last;
   logic [PCNT_W-1:0]  pulse_seen;
   logic               cnt_clr;

   pt_sync_edge #(.STAGES(SYNC_STAGES)) u_src_sync (
      .clk(clk), .rst_n(rst_n), .din(src_in),
      .fall_sel(cfg_src_fall), .stb(src_stb)
   );

   pt_sync_edge #(.STAGES(SYNC_STAGES)) u_gate_sync (
      .clk(clk), .rst_n(rst_n), .din(gate_in),
      .fall_sel(1'b0), .stb(gate_stb)
   );

   assign cnt_clr = !arm || (state == PT_IDLE);

   always_comb begin
      unique case (state)
         PT_DELAY: phase_lim = delay_len;
         PT_HIGH:  phase_lim = high_len;
         PT_LOW:   phase_lim = low_len;
         default:  phase_lim = delay_len;
      endcase
   end

   pt_phase_cnt #(.W(CNT_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .step(src_stb),
      .limit(phase_lim), .hit(phase_hit), .count(phase_count)
   );

   pt_pulse_cnt #(.W(PCNT_W)) u_pulses (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(pulse_inc),
      .total(pulse_total), .last(pulse_last), .count(pulse_seen)
   );

   always_comb begin
      state_n   = state;
      finish    = 1'b0;
      pulse_inc = 1'b0;
      first_set = 1'b0;
      if (!arm) begin
         state_n = PT_IDLE;
      end else begin
         unique case (state)
            PT_IDLE: begin
               if (gate_stb) begin
                  first_set = 1'b1;
                  state_n   = (!first_used || cfg_delay_all) ? PT_DELAY : PT_HIGH;
               end
            end
            PT_DELAY: begin
               if (phase_hit) state_n = PT_HIGH;
            end
            PT_HIGH: begin
               if (phase_hit) begin
                  if (!cfg_train || pulse_last) begin
                     state_n = PT_IDLE;
                     finish  = 1'b1;
                  end else begin
                     state_n   = PT_LOW;
                     pulse_inc = 1'b1;
                  end
               end
            end
            PT_LOW: begin
               if (phase_hit) state_n = PT_HIGH;
            end
            default: state_n = PT_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= PT_IDLE;
         pulse_out  <= 1'b0;
         done       <= 1'b0;
         first_used <= 1'b0;
      end else begin
         state     <= state_n;
         pulse_out <= arm && (state_n == PT_HIGH);
         done      <= finish;
         if (!arm)           first_used <= 1'b0;
         else if (first_set) first_used <= 1'b1;
      end
   end
endmodule

// File: rtl/pt_checker.sv
module pt_checker #(
   parameter int PCNT_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              arm,
   input logic              pulse_out,
   input logic              done,
   input logic              src_stb,
   input logic              gate_stb,
   input logic [PCNT_W-1:0] pcnt,
   input logic [PCNT_W-1:0] total
);
   logic [PCNT_W-1:0] tot_eff;
   assign tot_eff = (total == '0) ? PCNT_W'(1) : total;

   assert_disarm_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !arm |=> (!pulse_out && !done));

   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_at_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $fell(pulse_out));

   assert_out_on_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pulse_out) |-> $past(src_stb || gate_stb || !arm));

   assert_pulse_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pcnt < tot_eff);
endmodule

bind pulse_train_gen pt_checker #(.PCNT_W(PCNT_W)) u_pt_checker (
   .clk(clk), .rst_n(rst_n), .arm(arm), .pulse_out(pulse_out), .done(done),
   .src_stb(src_stb), .gate_stb(gate_stb), .pcnt(pulse_seen), .total(pulse_total)
);

// File: tb/tb_pulse_train_gen.sv
module tb_pulse_train_gen;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        arm = 1'b0;
   logic        src = 1'b0;
   logic        gate = 1'b0;
   logic        cfg_src_fall = 1'b0;
   logic        cfg_delay_all = 1'b1;
   logic        cfg_train = 1'b0;
   logic [15:0] delay_v = 16'd1;
   logic [15:0] high_v = 16'd1;
   logic [15:0] low_v = 16'd1;
   logic [15:0] total_v = 16'd1;
   logic        pulse_out;
   logic        done;
   logic        src_idle = 1'b0;

   int n_chk = 0;
   int n_err = 0;
   int done_cnt = 0;

   always #(CLK_P/2) clk = ~clk;

   pulse_train_gen dut (
      .clk(clk), .rst_n(rst_n), .arm(arm), .src_in(src), .gate_in(gate),
      .cfg_src_fall(cfg_src_fall), .cfg_delay_all(cfg_delay_all),
      .cfg_train(cfg_train), .delay_len(delay_v), .high_len(high_v),
      .low_len(low_v), .pulse_total(total_v), .pulse_out(pulse_out), .done(done)
   );

   always @(negedge clk) if (rst_n && done) done_cnt++;

   function automatic int eff(int v);
      return (v == 0) ? 1 : v;
   endfunction

   // expected output after the j-th active edge following a trigger
   function automatic bit exp_out(int j, int d, int h, int l, int p);
      int per;
      int q;
      per = h + l;
      if (j < d) return 1'b0;
      q = j - d;
      if (q >= (p - 1) * per + h) return 1'b0;
      return (q % per) < h;
   endfunction

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic fire();
      @(negedge clk) gate = 1'b1;
      repeat (4) @(negedge clk);
      gate = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic src_edge(bit inject, output bit smp);
      @(negedge clk) src = ~src_idle;
      repeat (4) @(negedge clk);
      smp = pulse_out;
      src = src_idle;
      gate = inject;
      repeat (4) @(negedge clk);
      gate = 1'b0;
   endtask

   task automatic rearm();
      @(negedge clk) arm = 1'b0;
      repeat (3) @(negedge clk);
      arm = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic run_gen(string req, int d, int h, int l, int p, int nedges, int gate_at);
      int d0;
      bit s;
      d0 = done_cnt;
      fire();
      check($sformatf("%s edge 0", req), pulse_out, exp_out(0, d, h, l, p));
      for (int j = 1; j <= nedges; j++) begin
         src_edge(j == gate_at, s);
         check($sformatf("%s edge %0d", req, j), s, exp_out(j, d, h, l, p));
      end
      check($sformatf("%s done count R10", req), done_cnt - d0, 1);
   endtask

   task automatic t_reset();
      check("R1 out after reset", pulse_out, 0);
      check("R1 done after reset", done, 0);
   endtask

   task automatic t_reference();
      cfg_train = 1'b0; cfg_delay_all = 1'b1;
      delay_v = 16'd5; high_v = 16'd3;
      run_gen("R2 single pulse first", 5, 3, 1, 1, 10, 0);
      run_gen("R7 R8 retrigger with delay", 5, 3, 1, 1, 10, 0);
   endtask

   task automatic t_first_only();
      cfg_train = 1'b1; cfg_delay_all = 1'b0;
      delay_v = 16'd4; high_v = 16'd2; low_v = 16'd3; total_v = 16'd3;
      rearm();
      run_gen("R8 first train delayed", 4, 2, 3, 3, 18, 0);
      run_gen("R8 retrain delay skipped", 0, 2, 3, 3, 16, 0);
   endtask

   task automatic t_train_ignore();
      cfg_train = 1'b1; cfg_delay_all = 1'b1;
      delay_v = 16'd2; high_v = 16'd2; low_v = 16'd2; total_v = 16'd4;
      run_gen("R4 R6 train with mid gate", 2, 2, 2, 4, 20, 5);
   endtask

   task automatic t_zeros();
      cfg_train = 1'b1; cfg_delay_all = 1'b1;
      delay_v = 16'd0; high_v = 16'd0; low_v = 16'd0; total_v = 16'd0;
      run_gen("R5 zero values", 1, 1, 1, 1, 4, 0);
   endtask

   task automatic t_abort();
      int d0;
      bit s;
      cfg_train = 1'b1; cfg_delay_all = 1'b0;
      delay_v = 16'd2; high_v = 16'd3; low_v = 16'd2; total_v = 16'd5;
      rearm();
      d0 = done_cnt;
      fire();
      for (int j = 1; j <= 4; j++) src_edge(1'b0, s);
      check("R9 high before abort", s, 1);
      @(negedge clk) arm = 1'b0;
      repeat (3) @(negedge clk);
      check("R9 out low after disarm", pulse_out, 0);
      fire();
      for (int j = 1; j <= 3; j++) begin
         src_edge(1'b0, s);
         check($sformatf("R9 disarmed edge %0d", j), s, 0);
      end
      check("R9 no done on abort", done_cnt - d0, 0);
      @(negedge clk) arm = 1'b1;
      repeat (3) @(negedge clk);
      run_gen("R9 full train after rearm", 2, 3, 2, 5, 27, 0);
   endtask

   task automatic t_falling();
      cfg_train = 1'b0; cfg_delay_all = 1'b1;
      delay_v = 16'd3; high_v = 16'd2;
      @(negedge clk) src_idle = 1'b1; src = 1'b1;
      repeat (4) @(negedge clk);
      cfg_src_fall = 1'b1;
      repeat (4) @(negedge clk);
      check("R3 rising edge not active", pulse_out, 0);
      run_gen("R3 falling edges", 3, 2, 1, 1, 7, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      arm = 1'b1;
      repeat (3) @(negedge clk);
      t_reference();
      t_first_only();
      t_train_ignore();
      t_zeros();
      t_abort();
      t_falling();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule